// File: doc/BRIEF.md
# LCD Scanline Mode Sequencer

This block steps a 160x144 LCD controller through its scanlines and display modes, one cycle at a time. A single counter tracks the cycle position within a 456-cycle line, and a second counter tracks the current line, which is exported as the line number. The current position is decoded into a 2-bit display mode and into access permits that tell the CPU side when video memory and sprite attribute memory are free.

The block also produces two interrupt requests. One pulse marks the start of vertical blank. The other is a status pulse that merges four separately enabled causes: a line-compare match, sprite-search entry, horizontal-blank entry and vertical-blank entry. When the display enable is low, the block stays at line 0, reports no events and grants free memory access. Raising the enable starts a fresh frame at line 0. All control and status pins are plain levels or single-cycle pulses, with no handshake. The block carries no data stream.

Top module: `lcd_mode_seq`

## Requirements
- R1: Every line lasts 456 cycles. The line number `ly` counts 0 to 153, advances by one when a line ends, and returns to 0 after line 153.
- R2: Mode encoding is 0 for horizontal blank, 1 for vertical blank, 2 for sprite search and 3 for pixel transfer. On lines 0 to 143, cycles 0–79 of the line are mode 2, cycles 80–249 are mode 3, and cycles 250–455 are mode 0.
- R3: On lines 144 to 153, every cycle of the line is mode 1.
- R4: `vblank_irq` is high for exactly the first cycle of line 144, once per frame. In that same cycle `stat_irq` is high if `en_vblank_irq` is set.
- R5: In the first cycle of any line, `stat_irq` is high if `en_lyc_irq` is set and `ly` equals `lyc`.
- R6: On lines 0 to 143, `stat_irq` is high in cycle 0 if `en_oam_irq` is set, and in cycle 250 if `en_hblank_irq` is set. When several causes fall in the same cycle they produce one single-cycle pulse. `stat_irq` is never high in any other cycle.
- R7: `oam_ok` is low in modes 2 and 3 and high otherwise. `vram_ok` is low in mode 3 only.
- R8: While `lcd_on` is low, `mode` is 0, both interrupt outputs are low and both permits are high. From the cycle after `lcd_on` falls, `ly` reads 0.
- R9: The first cycle with `lcd_on` high is line 0, cycle 0, in mode 2.
- R10: `ly_match` is high in the same cycle whenever `ly` equals `lyc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lcd_on | input | 1 | Display enable |
| lyc | input | 8 | Line compare value |
| en_lyc_irq | input | 1 | Enables the status pulse on a line-compare match |
| en_oam_irq | input | 1 | Enables the status pulse on sprite-search entry |
| en_vblank_irq | input | 1 | Enables the status pulse on vertical-blank entry |
| en_hblank_irq | input | 1 | Enables the status pulse on horizontal-blank entry |
| ly | output | 8 | Current line number |
| mode | output | 2 | Current display mode |
| ly_match | output | 1 | High when the line number equals the compare value |
| vblank_irq | output | 1 | Single-cycle pulse at the start of vertical blank |
| stat_irq | output | 1 | Single-cycle merged status interrupt pulse |
| vram_ok | output | 1 | CPU may access video memory |
| oam_ok | output | 1 | CPU may access sprite attribute memory |

## Verification
The mode-order and line-step properties assume `lcd_on` stays high for two consecutive sampled cycles, so they say nothing across an enable edge. The stimulus changes `lcd_on` only just after a clock edge and at points aligned to line boundaries. The status properties assume the four enables and `lyc` are quasi-static, so the stimulus changes them only while the display is off. The pulse-width properties rely on the fact that no two status causes can fall in adjacent cycles, and this holds for any legal compare value.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_OAM    = 2'd2,
    MODE_XFER   = 2'd3
  } lcd_mode_t;

  // status interrupt cause slots
  localparam int CAUSE_LYC    = 0;
  localparam int CAUSE_OAM    = 1;
  localparam int CAUSE_VBLANK = 2;
  localparam int CAUSE_HBLANK = 3;
  localparam int CAUSE_N      = 4;
endpackage

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
  parameter int LINE_CYCLES = 456,
  parameter int TOTAL_LINES = 154,
  localparam int DOT_W = $clog2(LINE_CYCLES),
  localparam int LY_W  = $clog2(TOTAL_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [DOT_W-1:0] dot,
  output logic [LY_W-1:0]  line
);
  localparam logic [DOT_W-1:0] DOT_LAST  = DOT_W'(LINE_CYCLES - 1);
  localparam logic [LY_W-1:0]  LINE_LAST = LY_W'(TOTAL_LINES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot  <= '0;
      line <= '0;
    end else if (!run) begin
      dot  <= '0;
      line <= '0;
    end else if (dot == DOT_LAST) begin
      dot  <= '0;
      line <= (line == LINE_LAST) ? '0 : line + 1'b1;
    end else begin
      dot <= dot + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_phase_decode.sv
module lcd_phase_decode
  import lcd_seq_pkg::*;
#(
  parameter int LINE_CYCLES   = 456,
  parameter int OAM_CYCLES    = 80,
  parameter int XFER_CYCLES   = 170,
  parameter int VISIBLE_LINES = 144,
  parameter int TOTAL_LINES   = 154,
  localparam int DOT_W = $clog2(LINE_CYCLES),
  localparam int LY_W  = $clog2(TOTAL_LINES)
) (
  input  logic             run,
  input  logic [DOT_W-1:0] dot,
  input  logic [LY_W-1:0]  line,
  output lcd_mode_t        mode,
  output logic             line_start,
  output logic             oam_entry,
  output logic             hblank_entry,
  output logic             vblank_entry,
  output logic             vram_ok,
  output logic             oam_ok
);
  localparam logic [DOT_W-1:0] XFER_START   = DOT_W'(OAM_CYCLES);
  localparam logic [DOT_W-1:0] HBLANK_START = DOT_W'(OAM_CYCLES + XFER_CYCLES);
  localparam logic [LY_W-1:0]  VBL_LINE     = LY_W'(VISIBLE_LINES);

  logic visible;
  assign visible = (line < VBL_LINE);

  assign line_start   = run && (dot == '0);
  assign oam_entry    = line_start && visible;
  assign vblank_entry = line_start && (line == VBL_LINE);
  assign hblank_entry = run && visible && (dot == HBLANK_START);

  always_comb begin
    if (!run)               mode = MODE_HBLANK;
    else if (!visible)      mode = MODE_VBLANK;
    else if (dot < XFER_START)   mode = MODE_OAM;
    else if (dot < HBLANK_START) mode = MODE_XFER;
    else                    mode = MODE_HBLANK;
  end

  assign oam_ok  = (mode == MODE_HBLANK) || (mode == MODE_VBLANK);
  assign vram_ok = (mode != MODE_XFER);
endmodule

// File: rtl/lcd_irq_merge.sv
module lcd_irq_merge
  import lcd_seq_pkg::*;
(
  input  logic [CAUSE_N-1:0] cause,
  input  logic [CAUSE_N-1:0] enable,
  output logic               stat_irq
);
  logic [CAUSE_N-1:0] gated;

  for (genvar g = 0; g < CAUSE_N; g++) begin : g_cause
    assign gated[g] = cause[g] & enable[g];
  end

  assign stat_irq = |gated;
endmodule

// File: rtl/lcd_mode_seq.sv
module lcd_mode_seq
  import lcd_seq_pkg::*;
#(
  parameter int LINE_CYCLES   = 456,
  parameter int OAM_CYCLES    = 80,
  parameter int XFER_CYCLES   = 170,
  parameter int VISIBLE_LINES = 144,
  parameter int TOTAL_LINES   = 154,
  localparam int DOT_W = $clog2(LINE_CYCLES),
  localparam int LY_W  = $clog2(TOTAL_LINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lcd_on,
  input  logic [LY_W-1:0] lyc,
  input  logic            en_lyc_irq,
  input  logic            en_oam_irq,
  input  logic            en_vblank_irq,
  input  logic            en_hblank_irq,
  output logic [LY_W-1:0] ly,
  output logic [1:0]      mode,
  output logic            ly_match,
  output logic            vblank_irq,
  output logic            stat_irq,
  output logic            vram_ok,
  output logic            oam_ok
);
  logic [DOT_W-1:0]   dot;
  lcd_mode_t          mode_q;
  logic               line_start, oam_entry, hblank_entry, vblank_entry;
  logic [CAUSE_N-1:0] cause, enable;

  lcd_line_timer #(
    .LINE_CYCLES(LINE_CYCLES),
    .TOTAL_LINES(TOTAL_LINES)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (lcd_on),
    .dot  (dot),
    .line (ly)
  );

  lcd_phase_decode #(
    .LINE_CYCLES  (LINE_CYCLES),
    .OAM_CYCLES   (OAM_CYCLES),
    .XFER_CYCLES  (XFER_CYCLES),
    .VISIBLE_LINES(VISIBLE_LINES),
    .TOTAL_LINES  (TOTAL_LINES)
  ) u_decode (
    .run         (lcd_on),
    .dot         (dot),
    .line        (ly),
    .mode        (mode_q),
    .line_start  (line_start),
    .oam_entry   (oam_entry),
    .hblank_entry(hblank_entry),
    .vblank_entry(vblank_entry),
    .vram_ok     (vram_ok),
    .oam_ok      (oam_ok)
  );

  assign ly_match = (ly == lyc);
  assign mode     = mode_q;

  assign cause[CAUSE_LYC]     = line_start && ly_match;
  assign cause[CAUSE_OAM]     = oam_entry;
  assign cause[CAUSE_VBLANK]  = vblank_entry;
  assign cause[CAUSE_HBLANK]  = hblank_entry;
  assign enable[CAUSE_LYC]    = en_lyc_irq;
  assign enable[CAUSE_OAM]    = en_oam_irq;
  assign enable[CAUSE_VBLANK] = en_vblank_irq;
  assign enable[CAUSE_HBLANK] = en_hblank_irq;

  lcd_irq_merge u_irq (
    .cause   (cause),
    .enable  (enable),
    .stat_irq(stat_irq)
  );

  assign vblank_irq = vblank_entry;
endmodule

// File: rtl/lcd_mode_seq_chk.sv
module lcd_mode_seq_chk #(
  parameter int VISIBLE_LINES = 144,
  parameter int TOTAL_LINES   = 154,
  localparam int LY_W = $clog2(TOTAL_LINES)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lcd_on,
  input logic [LY_W-1:0] lyc,
  input logic [LY_W-1:0] ly,
  input logic [1:0]      mode,
  input logic            ly_match,
  input logic            vblank_irq,
  input logic            stat_irq,
  input logic            vram_ok,
  input logic            oam_ok
);
  localparam logic [LY_W-1:0] VBL_LINE = LY_W'(VISIBLE_LINES);
  localparam logic [LY_W-1:0] LAST     = LY_W'(TOTAL_LINES - 1);

  a_r1_ly_range: assert property (@(posedge clk) disable iff (!rst_n)
    ly <= LAST);

  a_r1_ly_step: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on ##1 lcd_on) |-> (ly == $past(ly) || ly == $past(ly) + 1'b1 || ly == '0));

  a_r2_oam_then_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && mode == 2'd2 ##1 lcd_on && mode != 2'd2) |-> mode == 2'd3);

  a_r2_xfer_then_hblank: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && mode == 2'd3 ##1 lcd_on && mode != 2'd3) |-> mode == 2'd0);

  a_r3_vblank_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_on && ly >= VBL_LINE) |-> mode == 2'd1);

  a_r4_vblank_entry: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |-> (mode == 2'd1 && ly == VBL_LINE));

  a_r4_vblank_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |=> !vblank_irq);

  a_r6_stat_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stat_irq |=> !stat_irq);

  a_r7_oam_block: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 || mode == 2'd3) |-> !oam_ok);

  a_r7_vram_block: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> !vram_ok);

  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |-> (!vblank_irq && !stat_irq && vram_ok && oam_ok && mode == 2'd0));

  a_r8_off_ly_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_on |=> ly == '0);

  a_r10_match: assert property (@(posedge clk) disable iff (!rst_n)
    ly_match == (ly == lyc));
endmodule

bind lcd_mode_seq lcd_mode_seq_chk #(
  .VISIBLE_LINES(VISIBLE_LINES),
  .TOTAL_LINES  (TOTAL_LINES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lcd_on    (lcd_on),
  .lyc       (lyc),
  .ly        (ly),
  .mode      (mode),
  .ly_match  (ly_match),
  .vblank_irq(vblank_irq),
  .stat_irq  (stat_irq),
  .vram_ok   (vram_ok),
  .oam_ok    (oam_ok)
);

// File: tb/lcd_mode_seq_bench.sv
`timescale 1ns/1ps
module lcd_mode_seq_bench;
  localparam int LINE  = 456;
  localparam int VIS   = 144;
  localparam int TOTAL = 154;

  typedef struct {
    int t;
    bit vb;
    bit st;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lcd_on = 1'b0;
  logic [7:0] lyc = 8'd0;
  logic       en_lyc_irq = 1'b0, en_oam_irq = 1'b0, en_vblank_irq = 1'b0, en_hblank_irq = 1'b0;
  logic [7:0] ly;
  logic [1:0] mode;
  logic       ly_match, vblank_irq, stat_irq, vram_ok, oam_ok;

  int checks = 0;
  int errors = 0;
  ev_t evq[$];
  bit  mon_on = 1'b0;
  int  t = 0, t_limit = 0;
  int  m_line, m_dot, m_ly, m_exp;
  int  mode_bad = 0, acc_bad = 0, match_bad = 0;
  ev_t e;

  always #10 clk = ~clk;

  lcd_mode_seq u_lcd_mode_seq (
    .clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .lyc(lyc),
    .en_lyc_irq(en_lyc_irq), .en_oam_irq(en_oam_irq),
    .en_vblank_irq(en_vblank_irq), .en_hblank_irq(en_hblank_irq),
    .ly(ly), .mode(mode), .ly_match(ly_match), .vblank_irq(vblank_irq),
    .stat_irq(stat_irq), .vram_ok(vram_ok), .oam_ok(oam_ok)
  );

  task automatic chk_val(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: expected interrupt events of a run that starts at line 0
  task automatic push_run(input int lines, input int lyc_v,
                          input bit e_lyc, input bit e_oam, input bit e_vb, input bit e_hb);
    for (int n = 0; n < lines; n++) begin
      int  l = n % TOTAL;
      bit  vb = (l == VIS);
      bit  st = (e_lyc && l == lyc_v) || (e_oam && l < VIS) || (e_vb && l == VIS);
      if (vb || st) evq.push_back('{t: n * LINE, vb: vb, st: st});
      if (l < VIS && e_hb) evq.push_back('{t: n * LINE + 250, vb: 1'b0, st: 1'b1});
    end
  endtask

  // monitor: per-cycle mode/permit model and event scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      m_line = t / LINE;
      m_dot  = t % LINE;
      m_ly   = m_line % TOTAL;
      if (m_ly >= VIS)     m_exp = 1;
      else if (m_dot < 80)  m_exp = 2;
      else if (m_dot < 250) m_exp = 3;
      else                  m_exp = 0;
      if (int'(mode) != m_exp) mode_bad++;
      if (oam_ok !== (m_exp < 2) || vram_ok !== (m_exp != 3)) acc_bad++;
      if (ly_match !== (ly == lyc)) match_bad++;
      if (m_dot == 0) chk_val(int'(ly) == m_ly, "R1 line number at line start", int'(ly), m_ly);
      if (t == 0) chk_val(int'(mode) == 2 && ly == 8'd0, "R9 first enabled cycle", int'(mode), 2);
      if (vblank_irq || stat_irq || (evq.size() != 0 && evq[0].t == t)) begin
        if (evq.size() == 0) begin
          chk_val(1'b0, "R6 unexpected pulse at cycle", t, -1);
        end else begin
          e = evq.pop_front();
          chk_val(e.t == t && e.vb == vblank_irq && e.st == stat_irq,
                  e.vb ? "R4 vblank pulse (t*4+vb*2+st)" : "R5 R6 status pulse (t*4+vb*2+st)",
                  t * 4 + int'(vblank_irq) * 2 + int'(stat_irq),
                  e.t * 4 + int'(e.vb) * 2 + int'(e.st));
        end
      end
      if (m_dot == LINE - 1) begin
        chk_val(mode_bad == 0, (m_ly >= VIS) ? "R3 mode cycles on blank line" : "R2 mode cycles on visible line",
                mode_bad, 0);
        chk_val(acc_bad == 0, "R7 access permits", acc_bad, 0);
        chk_val(match_bad == 0, "R10 compare flag", match_bad, 0);
        mode_bad = 0; acc_bad = 0; match_bad = 0;
      end
      t++;
      if (t == t_limit) mon_on = 1'b0;
    end
  end

  task automatic start_run(input int lines);
    @(posedge clk); #1;
    t = 0; t_limit = lines * LINE; mon_on = 1'b1; lcd_on = 1'b1;
    wait (mon_on == 1'b0);
    chk_val(evq.size() == 0, "R4 R6 all expected pulses seen", evq.size(), 0);
  endtask

  task automatic quiet_off(input int cycles);
    @(posedge clk); #1;
    lcd_on = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (vblank_irq || stat_irq || mode != 2'd0 || !vram_ok || !oam_ok || (i > 0 && ly != 8'd0))
        acc_bad++;
    end
    chk_val(acc_bad == 0, "R8 display disabled state", acc_bad, 0);
    acc_bad = 0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk_val(1'b0, "R1 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk_val(ly == 8'd0 && mode == 2'd0, "R8 reset line and mode", int'(ly) * 4 + int'(mode), 0);
    chk_val(!vblank_irq && !stat_irq && vram_ok && oam_ok, "R8 reset pulses and permits",
            {vblank_irq, stat_irq, vram_ok, oam_ok}, 3);

    // full frame plus one wrapped line, every cause enabled
    lyc = 8'd5;
    en_lyc_irq = 1'b1; en_oam_irq = 1'b1; en_vblank_irq = 1'b1; en_hblank_irq = 1'b1;
    push_run(TOTAL + 1, 5, 1'b1, 1'b1, 1'b1, 1'b1);
    start_run(TOTAL + 1);
    quiet_off(300);

    // compare match on the first blank line only
    lyc = 8'd144;
    en_oam_irq = 1'b0; en_vblank_irq = 1'b0; en_hblank_irq = 1'b0;
    push_run(150, 144, 1'b1, 1'b0, 1'b0, 1'b0);
    start_run(150);
    quiet_off(100);

    // enable again after a mid-frame stop
    @(posedge clk); #1 lcd_on = 1'b1;
    @(negedge clk);
    chk_val(ly == 8'd0 && mode == 2'd2, "R9 restart at line 0 in mode 2", int'(ly) * 4 + int'(mode), 2);
    chk_val(!oam_ok && vram_ok, "R7 permits in sprite search", {oam_ok, vram_ok}, 1);
    finish_run();
  end
endmodule